// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside an SDRAM controller or a protocol monitor and follows a stream of already-decoded SDRAM commands, one per clock. It keeps a small state machine for each of four banks (idle, row open, or closing) and reports the row that each open bank holds. It raises an error pulse for any command that the present bank states forbid, and a separate pulse for a command that comes before the row-open delay or the close delay has run out.

Each bank machine counts its own row-open delay and close delay in clock cycles. It also counts down a per-command automatic close that a READ or WRITE requests by setting address bit 10. A small burst tracker remembers which bank owns the burst in progress, so that a burst stop command aimed at another bank is caught. Commands that require every bank to be closed (refresh and mode-register load) are checked against all four machines at once.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After a synchronous reset every bank reads idle (code 0), every open-row field reads 0, and both error outputs are low. Bank b's state sits at `bank_state[2b+1:2b]` (0 idle, 1 open, 2 closing); its row sits at `open_row[12b+11:12b]`.
- R2: An ACTIVE (cmd 1) to an idle bank makes that bank read open after the registering edge, with `open_row` equal to `addr`; no other bank changes.
- R3: An ACTIVE to a bank that is already open raises `illegal_err`; the bank keeps its state and its row.
- R4: A READ (cmd 2) or WRITE (cmd 3) to a bank that is idle or closing raises `illegal_err`.
- R5: A READ or WRITE that arrives fewer than TRCD cycles after the ACTIVE of its bank raises `timing_err` and is dropped; one that arrives exactly TRCD cycles after is accepted with no error.
- R6: A PRECHARGE (cmd 4) with `addr[10]` low closes only the addressed open bank; with `addr[10]` high it closes every open bank. A closed bank reads closing (row 0) for TRP cycles and then reads idle; banks not closed keep their state and row.
- R7: An ACTIVE to a closing bank before TRP cycles have passed since its close raises `timing_err`; an ACTIVE exactly TRP cycles after the close is accepted.
- R8: A READ or WRITE with `addr[10]` high leaves the bank open for BURST_LEN cycles and then closes it on its own, followed by the TRP closing period. While that close is pending, a READ, WRITE or PRECHARGE to the bank, or an all-bank PRECHARGE, raises `illegal_err`.
- R9: AUTO REFRESH (cmd 5) and LOAD MODE (cmd 6) are accepted only when every bank is idle or has finished its closing period; otherwise they raise `illegal_err`.
- R10: BURST TERMINATE (cmd 7) is accepted only if it names the bank of the last accepted READ or WRITE and comes 1 to BURST_LEN cycles after it, with no close of that bank in between; otherwise it raises `illegal_err`. When accepted on a burst that requested automatic close, the bank starts its closing period at once.
- R11: A flagged command changes no bank state. Each error output is a one-cycle pulse that appears in the cycle after the command's registering edge; NOP (cmd 0) never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command code, one per cycle |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address for ACTIVE; bit 10 selects auto close or all banks |
| bank_state | output | 8 | Two-bit state per bank |
| open_row | output | 48 | Open row per bank, 0 when not open |
| illegal_err | output | 1 | Pulse: command forbidden in the present bank state |
| timing_err | output | 1 | Pulse: command before the row-open or close delay ran out |

## Verification
Every result is registered, so the state, row and error outputs for a command show the effect of the edge that captured it and are read half a cycle later, before any further command lands. The delay checks place commands at offsets counted from that edge: one and two cycles after an ACTIVE must be refused and exactly TRCD cycles after must pass, while the closing state is read at TRP-1 cycles and again at TRP cycles after a close. Automatic close is watched at BURST_LEN-1 and BURST_LEN cycles after the access, and each error pulse is read once more on the following NOP to confirm that it has dropped.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_ACT = 3'd1,
    C_RD  = 3'd2,
    C_WR  = 3'd3,
    C_PRE = 3'd4,
    C_REF = 3'd5,
    C_LMR = 3'd6,
    C_BST = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2
  } bank_st_e;
endpackage

// File: rtl/sbt_bank.sv
module sbt_bank
  import sbt_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_act,
  input  logic             do_rw,
  input  logic             rw_ap,
  input  logic             do_pre,
  input  logic             do_cut,
  input  logic [ROW_W-1:0] row_in,
  output logic [1:0]       state_o,
  output logic [ROW_W-1:0] row_o,
  output logic             idle_ok_o,
  output logic             rw_ok_o,
  output logic             rcd_busy_o,
  output logic             is_open_o,
  output logic             ap_pend_o
);
  localparam int RCD_W = $clog2(TRCD + 1);
  localparam int RP_W  = $clog2(TRP + 1);
  localparam int BL_W  = $clog2(BURST_LEN + 1);

  bank_st_e         st;
  logic [ROW_W-1:0] row;
  logic [RCD_W-1:0] rcd_cnt;
  logic [RP_W-1:0]  rp_cnt;
  logic [BL_W-1:0]  ap_cnt;
  logic             ap_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BK_IDLE;
      row     <= '0;
      rcd_cnt <= '0;
      rp_cnt  <= '0;
      ap_cnt  <= '0;
      ap_pend <= 1'b0;
    end else begin
      case (st)
        BK_IDLE: begin
          if (do_act) begin
            st      <= BK_OPEN;
            row     <= row_in;
            rcd_cnt <= RCD_W'(TRCD - 1);
          end
        end
        BK_OPEN: begin
          if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
          if (do_pre || (do_cut && ap_pend)) begin
            st      <= BK_CLOSING;
            row     <= '0;
            rp_cnt  <= RP_W'(TRP - 1);
            ap_pend <= 1'b0;
          end else if (ap_pend) begin
            if (ap_cnt == '0) begin
              st      <= BK_CLOSING;
              row     <= '0;
              rp_cnt  <= RP_W'(TRP - 1);
              ap_pend <= 1'b0;
            end else begin
              ap_cnt <= ap_cnt - 1'b1;
            end
          end else if (do_rw && rw_ap) begin
            ap_pend <= 1'b1;
            ap_cnt  <= BL_W'(BURST_LEN - 1);
          end
        end
        BK_CLOSING: begin
          if (do_act) begin
            st      <= BK_OPEN;
            row     <= row_in;
            rcd_cnt <= RCD_W'(TRCD - 1);
          end else if (rp_cnt == '0) begin
            st <= BK_IDLE;
          end else begin
            rp_cnt <= rp_cnt - 1'b1;
          end
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  assign state_o    = st;
  assign row_o      = row;
  assign is_open_o  = (st == BK_OPEN);
  assign idle_ok_o  = (st == BK_IDLE) || ((st == BK_CLOSING) && (rp_cnt == '0));
  assign rw_ok_o    = (st == BK_OPEN) && (rcd_cnt == '0) && !ap_pend;
  assign rcd_busy_o = (st == BK_OPEN) && (rcd_cnt != '0) && !ap_pend;
  assign ap_pend_o  = ap_pend;

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_IDLE && !do_act) |=> (st == BK_IDLE));

  // R2
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_IDLE && do_act) |=> (st == BK_OPEN && row == $past(row_in)));

  // R6
  open_close_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_OPEN) |=> (st != BK_IDLE));

  // R8
  ap_open_chk: assert property (@(posedge clk) disable iff (rst)
    ap_pend |-> (st == BK_OPEN));
endmodule

// File: rtl/sbt_rules.sv
module sbt_rules
  import sbt_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic [NB-1:0]   idle_ok,
  input  logic [NB-1:0]   rw_ok,
  input  logic [NB-1:0]   rcd_busy,
  input  logic [NB-1:0]   is_open,
  input  logic [NB-1:0]   ap_pend,
  input  logic            burst_live,
  input  logic [BA_W-1:0] burst_bank,
  output logic [NB-1:0]   act_v,
  output logic [NB-1:0]   rw_v,
  output logic [NB-1:0]   pre_v,
  output logic [NB-1:0]   cut_v,
  output logic            bst_ok,
  output logic            bad,
  output logic            early
);
  logic [NB-1:0] sel;

  always_comb begin
    sel    = NB'(1) << ba;
    act_v  = '0;
    rw_v   = '0;
    pre_v  = '0;
    cut_v  = '0;
    bst_ok = 1'b0;
    bad    = 1'b0;
    early  = 1'b0;
    case (cmd)
      C_ACT: begin
        if (idle_ok[ba])      act_v = sel;
        else if (!is_open[ba]) early = 1'b1;
        else                   bad   = 1'b1;
      end
      C_RD, C_WR: begin
        if (rw_ok[ba])         rw_v  = sel;
        else if (rcd_busy[ba]) early = 1'b1;
        else                   bad   = 1'b1;
      end
      C_PRE: begin
        if (a10) begin
          if (|ap_pend) bad = 1'b1;
          else          pre_v = is_open;
        end else begin
          if (ap_pend[ba]) bad = 1'b1;
          else             pre_v = sel & is_open;
        end
      end
      C_REF, C_LMR: begin
        if (!(&idle_ok)) bad = 1'b1;
      end
      C_BST: begin
        if (burst_live && (burst_bank == ba)) begin
          cut_v  = sel;
          bst_ok = 1'b1;
        end else begin
          bad = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sbt_burst.sv
module sbt_burst #(
  parameter int NB        = 4,
  parameter int BA_W      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BA_W-1:0] start_bank,
  input  logic            cut,
  input  logic [NB-1:0]   close_mask,
  output logic            live_o,
  output logic [BA_W-1:0] bank_o
);
  localparam int BL_W = $clog2(BURST_LEN + 1);

  logic [BL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_o <= 1'b0;
      bank_o <= '0;
      cnt    <= '0;
    end else if (start) begin
      live_o <= 1'b1;
      bank_o <= start_bank;
      cnt    <= BL_W'(BURST_LEN - 1);
    end else if (live_o) begin
      if (cut || close_mask[bank_o] || (cnt == '0)) live_o <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  // R10
  burst_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (live_o && bank_o == $past(start_bank)));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NB        = 4,
  parameter int ROW_W     = 12,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int BURST_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            cmd,
  input  logic [$clog2(NB)-1:0] ba,
  input  logic [ROW_W-1:0]      addr,
  output logic [2*NB-1:0]       bank_state,
  output logic [NB*ROW_W-1:0]   open_row,
  output logic                  illegal_err,
  output logic                  timing_err
);
  localparam int BA_W = $clog2(NB);

  cmd_e            cmd_q;
  logic [NB-1:0]   idle_ok, rw_ok, rcd_busy, is_open, ap_pend;
  logic [NB-1:0]   act_v, rw_v, pre_v, cut_v;
  logic            bst_ok, bad, early;
  logic            burst_live;
  logic [BA_W-1:0] burst_bank;

  assign cmd_q = cmd_e'(cmd);

  sbt_rules #(.NB(NB), .BA_W(BA_W)) u_rules (
    .cmd(cmd_q), .ba(ba), .a10(addr[10]),
    .idle_ok(idle_ok), .rw_ok(rw_ok), .rcd_busy(rcd_busy),
    .is_open(is_open), .ap_pend(ap_pend),
    .burst_live(burst_live), .burst_bank(burst_bank),
    .act_v(act_v), .rw_v(rw_v), .pre_v(pre_v), .cut_v(cut_v),
    .bst_ok(bst_ok), .bad(bad), .early(early)
  );

  sbt_burst #(.NB(NB), .BA_W(BA_W), .BURST_LEN(BURST_LEN)) u_burst (
    .clk(clk), .rst(rst), .start(|rw_v), .start_bank(ba),
    .cut(bst_ok), .close_mask(pre_v),
    .live_o(burst_live), .bank_o(burst_bank)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sbt_bank #(.ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP), .BURST_LEN(BURST_LEN)) u_bank (
      .clk(clk), .rst(rst),
      .do_act(act_v[g]), .do_rw(rw_v[g]), .rw_ap(addr[10]),
      .do_pre(pre_v[g]), .do_cut(cut_v[g]), .row_in(addr),
      .state_o(bank_state[2*g +: 2]), .row_o(open_row[ROW_W*g +: ROW_W]),
      .idle_ok_o(idle_ok[g]), .rw_ok_o(rw_ok[g]), .rcd_busy_o(rcd_busy[g]),
      .is_open_o(is_open[g]), .ap_pend_o(ap_pend[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_err <= 1'b0;
      timing_err  <= 1'b0;
    end else begin
      illegal_err <= bad;
      timing_err  <= early;
    end
  end

  // R9
  busy_ref_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd_q == C_REF || cmd_q == C_LMR) && !(&idle_ok)) |=> illegal_err);

  // R5
  timing_src_chk: assert property (@(posedge clk) disable iff (rst)
    timing_err |-> ($past(cmd_q) == C_ACT || $past(cmd_q) == C_RD || $past(cmd_q) == C_WR));

  // R11
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(illegal_err && timing_err));

  // R10
  bst_orphan_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == C_BST && !burst_live) |=> illegal_err);
endmodule

// File: tb/sdram_bank_tracker_tb_top.sv
module sdram_bank_tracker_tb_top;
  localparam int TRCD = 3;
  localparam int TRP  = 3;
  localparam int BL   = 4;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5, LMR = 3'd6, BST = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = NOP;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [7:0]  bank_state;
  logic [47:0] open_row;
  logic        illegal_err, timing_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sdram_bank_tracker #(.TRCD(TRCD), .TRP(TRP), .BURST_LEN(BL)) dut_i (
    .clk(clk), .rst(rst), .cmd(cmd), .ba(ba), .addr(addr),
    .bank_state(bank_state), .open_row(open_row),
    .illegal_err(illegal_err), .timing_err(timing_err)
  );

  function automatic int st(int b);
    return int'(bank_state[2*b +: 2]);
  endfunction

  function automatic int rw(int b);
    return int'(open_row[12*b +: 12]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic errs(string tag, int ill, int tim);
    chk({tag, " illegal_err"}, int'(illegal_err), ill);
    chk({tag, " timing_err"}, int'(timing_err), tim);
  endtask

  // Called at a falling edge; the command is captured at the next rising edge
  // and the task returns at the falling edge after it.
  task automatic issue(logic [2:0] c, int b, int a);
    cmd = c; ba = 2'(b); addr = 12'(a);
    @(negedge clk);
    cmd = NOP; ba = '0; addr = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd = NOP;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 bank_state", int'(bank_state), 0);
    chk("R1 open_row", int'(open_row != 0), 0);
    errs("R1", 0, 0);
  endtask

  task automatic t_activate();
    do_reset();
    issue(ACT, 1, 'hABC);
    chk("R2 bank1 state", st(1), 1);
    chk("R2 bank1 row", rw(1), 'hABC);
    chk("R2 others idle", st(0) + st(2) + st(3), 0);
    errs("R2", 0, 0);
    issue(ACT, 1, 'h111);
    errs("R3 second ACTIVE", 1, 0);
    chk("R3 row kept", rw(1), 'hABC);
    chk("R3 state kept", st(1), 1);
    idle(1);
    errs("R11 pulse ends", 0, 0);
  endtask

  task automatic t_rw_closed();
    do_reset();
    issue(RD, 2, 0);
    errs("R4 READ idle bank", 1, 0);
    issue(WR, 2, 0);
    errs("R4 WRITE idle bank", 1, 0);
    chk("R11 bank2 unchanged", st(2), 0);
  endtask

  task automatic t_rcd_rp();
    do_reset();
    issue(ACT, 0, 'h055);
    issue(RD, 0, 0);
    errs("R5 READ at +1", 0, 1);
    issue(WR, 0, 0);
    errs("R5 WRITE at +2", 0, 1);
    issue(RD, 0, 0);
    errs("R5 READ at TRCD", 0, 0);
    issue(PRE, 0, 0);
    chk("R6 closing", st(0), 2);
    chk("R6 row cleared", rw(0), 0);
    issue(ACT, 0, 'h077);
    errs("R7 ACTIVE during close", 0, 1);
    idle(1);
    chk("R6 closing at TRP-1", st(0), 2);
    issue(ACT, 0, 'h077);
    errs("R7 ACTIVE at TRP", 0, 0);
    chk("R7 reopened row", rw(0), 'h077);
  endtask

  task automatic t_pre_all();
    do_reset();
    issue(ACT, 0, 'h010);
    issue(ACT, 1, 'h020);
    issue(ACT, 3, 'h030);
    issue(PRE, 1, 0);
    chk("R6 bank1 closing", st(1), 2);
    chk("R6 bank0 untouched", st(0), 1);
    chk("R6 bank3 row kept", rw(3), 'h030);
    idle(3);
    issue(PRE, 0, 'h400);
    chk("R6 all: bank0 closing", st(0), 2);
    chk("R6 all: bank3 closing", st(3), 2);
    chk("R6 all: bank2 stays idle", st(2), 0);
    idle(TRP - 1);
    chk("R6 all: still closing", st(3), 2);
    idle(1);
    chk("R6 all: idle after TRP", int'(bank_state), 0);
  endtask

  task automatic t_autopre();
    do_reset();
    issue(ACT, 2, 'h123);
    idle(TRCD - 1);
    issue(RD, 2, 'h400);
    errs("R8 READ auto close", 0, 0);
    chk("R8 open after access", st(2), 1);
    issue(RD, 2, 0);
    errs("R8 READ while pending", 1, 0);
    issue(PRE, 2, 0);
    errs("R8 PRECHARGE while pending", 1, 0);
    idle(BL - 3);
    chk("R8 open at BURST_LEN-1", st(2), 1);
    idle(1);
    chk("R8 closing at BURST_LEN", st(2), 2);
    idle(TRP);
    chk("R8 idle after TRP", st(2), 0);
  endtask

  task automatic t_refresh();
    do_reset();
    issue(REF, 0, 0);
    errs("R9 REF all idle", 0, 0);
    issue(LMR, 0, 'h032);
    errs("R9 LMR all idle", 0, 0);
    issue(ACT, 1, 'h005);
    issue(REF, 0, 0);
    errs("R9 REF bank open", 1, 0);
    issue(LMR, 0, 0);
    errs("R9 LMR bank open", 1, 0);
    chk("R11 bank1 still open", st(1), 1);
    issue(PRE, 1, 0);
    issue(REF, 0, 0);
    errs("R9 REF while closing", 1, 0);
    idle(TRP - 2);
    issue(REF, 0, 0);
    errs("R9 REF after TRP", 0, 0);
  endtask

  task automatic t_bst();
    do_reset();
    issue(BST, 0, 0);
    errs("R10 BST no burst", 1, 0);
    issue(ACT, 0, 'h001);
    idle(TRCD - 1);
    issue(RD, 0, 0);
    issue(BST, 1, 0);
    errs("R10 BST other bank", 1, 0);
    issue(BST, 0, 0);
    errs("R10 BST own bank", 0, 0);
    issue(BST, 0, 0);
    errs("R10 BST after cut", 1, 0);
    issue(ACT, 3, 'h0F0);
    idle(TRCD - 1);
    issue(WR, 3, 'h400);
    idle(BL - 1);
    issue(BST, 3, 0);
    errs("R10 BST at BURST_LEN", 0, 0);
    chk("R10 auto close starts", st(3), 2);
    issue(ACT, 2, 'h002);
    idle(TRCD - 1);
    issue(WR, 2, 0);
    idle(BL);
    issue(BST, 2, 0);
    errs("R10 BST past burst", 1, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_activate();
    t_rw_closed();
    t_rcd_rp();
    t_pre_all();
    t_autopre();
    t_refresh();
    t_bst();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule